// File: doc/BRIEF.md
# Self-Timed Page Write Commit Controller

This block sits between the two-wire protocol engine of a serial byte-wide memory and its storage array. It collects the data bytes of one write transfer in a page-sized staging buffer. The bytes are committed to the array only when a stop condition closes the transfer. A stop that arrives while write protect is high commits nothing. A start that arrives before the stop throws the staged bytes away.

The commit is a self-timed cycle of a fixed number of system clocks. While it runs, the block raises `busy`. The protocol engine uses `busy` to withhold its acknowledge, so acknowledge polling by a bus master only succeeds after the cycle has ended. Every strobe from the engine is ignored during the cycle.

The array write port sees one write per staged byte, and only for page slots that received a byte. A `done` pulse marks the end of the cycle.

Top module: `selftimed_write_ctrl`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `mem_we` are all low.
- R2: A `stop_seen` strobe, with `wp` low, after at least one data byte of the current transfer raises `busy` on the next cycle. `busy` then stays high for exactly CYCLE_CLKS consecutive cycles.
- R3: `done` is high for exactly one cycle, namely the first cycle in which `busy` is low again after a commit.
- R4: A stop that ends a transfer carrying no data bytes (an address only, as in a dummy write) starts no cycle and writes nothing.
- R5: A `start_seen` strobe before the stop discards the staged bytes. No cycle starts and the array is unchanged.
- R6: If `wp` is high when the stop arrives, no cycle starts and the array is unchanged. The whole array is protected.
- R7: Only page slots that received a byte are written. Each such slot is written once, at address {row of `addr_in`, slot index}, with the byte last received for it.
- R8: The slot index starts at the low bits of `addr_in` and advances by one per byte. It wraps to slot 0 of the same page, so a later byte for a slot replaces an earlier one.
- R9: While `busy` is high, `byte_vld`, `addr_vld`, `stop_seen` and `start_seen` have no effect. They neither alter the committed data nor start a further cycle.
- R10: The page holds 8 bytes when ADDR_W is 8 and 16 bytes when ADDR_W is larger. The slot index is therefore the low 3 or 4 address bits.
- R11: `mem_we` is asserted only in a cycle that directly follows a cycle with `busy` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_seen | input | 1 | Start condition strobe from the protocol engine |
| addr_vld | input | 1 | Word address of a write transfer received |
| addr_in | input | ADDR_W | Word address value |
| byte_vld | input | 1 | Data byte of a write transfer received |
| byte_in | input | 8 | Data byte value |
| stop_seen | input | 1 | Stop condition strobe |
| wp | input | 1 | Write protect, high protects the whole array |
| busy | output | 1 | Commit cycle running; engine must not acknowledge |
| done | output | 1 | One-cycle pulse at the end of a commit |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The checker watches, on every cycle, the length of each `busy` run and the single-cycle `done` that follows it. It also confirms that array writes occur only inside a commit and that a stop under write protect never raises `busy`. Only the bench scenarios can show which bytes land at which addresses: page wrap, overwrites within a page, partial pages, discarded aborted transfers, and strobes that are injected during a commit and must leave the array untouched. The bench compares its own model of the array after each transfer.

// File: rtl/stw_pkg.sv
package stw_pkg;
  // Page size follows density: smallest array uses 8-byte pages.
  function automatic int page_bytes_for(input int addr_w);
    return (addr_w <= 8) ? 8 : 16;
  endfunction
endpackage

// File: rtl/stw_page_buf.sv
module stw_page_buf #(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic          any_valid
);
  logic [7:0]       store [DEPTH];
  logic [DEPTH-1:0] vmask;

  // Data storage without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
    rd_data <= store[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vmask <= '0;
    else if (wr_en) vmask[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_en && vmask[rd_idx];
  end

  assign any_valid = |vmask;
endmodule

// File: rtl/stw_cycle_timer.sv
module stw_cycle_timer #(
  parameter int unsigned CYCLES = 40,
  parameter int          CW     = $clog2(CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] cnt,
  output logic          last
);
  assign last = busy && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= last;
      if (launch && !busy) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/selftimed_write_ctrl.sv
module selftimed_write_ctrl #(
  parameter int          ADDR_W     = 8,
  parameter int unsigned CYCLE_CLKS = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_seen,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic              stop_seen,
  input  logic              wp,
  output logic              busy,
  output logic              done,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int PAGE = stw_pkg::page_bytes_for(ADDR_W);
  localparam int PW   = $clog2(PAGE);
  localparam int RW   = ADDR_W - PW;
  localparam int CW   = $clog2(CYCLE_CLKS + 1);

  logic          accept, any_data, launch, buf_clr, buf_wr, fin, rd_en;
  logic [RW-1:0] row_q;
  logic [PW-1:0] off_q, rd_idx;
  logic [CW-1:0] tcnt;

  assign accept  = !busy;
  assign buf_wr  = accept && byte_vld;
  assign launch  = accept && stop_seen && any_data && !wp;
  assign buf_clr = fin || (accept && (start_seen || addr_vld || (stop_seen && !launch)));
  assign rd_en   = busy && (tcnt < CW'(PAGE));
  assign rd_idx  = tcnt[PW-1:0];

  // Row is held for the commit; slot offset wraps inside the page.
  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      off_q <= '0;
    end else if (accept && addr_vld) begin
      {row_q, off_q} <= addr_in;
    end else if (buf_wr) begin
      off_q <= off_q + 1'b1;
    end
  end

  stw_page_buf #(.DEPTH(PAGE), .IW(PW)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .clr      (buf_clr),
    .wr_en    (buf_wr),
    .wr_idx   (off_q),
    .wr_data  (byte_in),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .rd_data  (mem_wdata),
    .rd_valid (mem_we),
    .any_valid(any_data)
  );

  stw_cycle_timer #(.CYCLES(CYCLE_CLKS), .CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .launch(launch),
    .busy  (busy),
    .done  (done),
    .cnt   (tcnt),
    .last  (fin)
  );

  always_ff @(posedge clk) begin
    if (rst) mem_addr <= '0;
    else     mem_addr <= {row_q, rd_idx};
  end
endmodule

// File: rtl/stw_checker.sv
module stw_checker #(
  parameter int unsigned CYCLE_CLKS = 40
) (
  input logic clk,
  input logic rst,
  input logic stop_seen,
  input logic wp,
  input logic busy,
  input logic done,
  input logic mem_we
);
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= 0;
    else     run_len <= busy ? run_len + 1 : 0;
  end

  // R2: each busy run lasts exactly CYCLE_CLKS cycles
  a_r2_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == CYCLE_CLKS));

  // R2: busy only rises after an unprotected stop
  a_r2_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(stop_seen) && !$past(wp)));

  // R3: done follows the end of busy
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R3: done is a single-cycle pulse
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: protected stop never launches a cycle
  a_r6_wp_blocks: assert property (@(posedge clk) disable iff (rst)
    ($past(stop_seen) && $past(wp)) |-> !$rose(busy));

  // R11: array writes only inside a commit
  a_r11_we_in_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(busy));
endmodule

bind selftimed_write_ctrl stw_checker #(.CYCLE_CLKS(CYCLE_CLKS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .stop_seen(stop_seen),
  .wp       (wp),
  .busy     (busy),
  .done     (done),
  .mem_we   (mem_we)
);

// File: tb/selftimed_write_ctrl_bench.sv
module selftimed_write_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 8;
  localparam int CYC        = 40;
  localparam int PAGE       = (AW == 8) ? 8 : 16;
  localparam int NWORDS     = 2 ** AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_seen = 1'b0, addr_vld = 1'b0, byte_vld = 1'b0, stop_seen = 1'b0, wp = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [7:0]    byte_in = '0;
  logic          busy, done, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int wr_count = 0;
  logic [7:0] arr [NWORDS];
  logic [7:0] exp_arr [NWORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  selftimed_write_ctrl #(.ADDR_W(AW), .CYCLE_CLKS(CYC)) u_selftimed_write_ctrl (
    .clk(clk), .rst(rst), .start_seen(start_seen), .addr_vld(addr_vld), .addr_in(addr_in),
    .byte_vld(byte_vld), .byte_in(byte_in), .stop_seen(stop_seen), .wp(wp),
    .busy(busy), .done(done), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // Array model driven only by the write port.
  always @(posedge clk) begin
    if (mem_we) begin
      arr[mem_addr] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic cmp_arrays(input string req);
    int bad = -1;
    for (int i = 0; i < NWORDS; i++)
      if (bad < 0 && arr[i] !== exp_arr[i]) bad = i;
    if (bad < 0) chk(req, 1'b1, 0, 0);
    else chk(req, 1'b0, int'(arr[bad]), int'(exp_arr[bad]));
  endtask

  task automatic pulse_byte(input logic [7:0] d);
    byte_in = d; byte_vld = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic do_xfer(input logic [7:0] a, input int n, input bit wpv,
                         input bit abort, input bit disturb, input string req);
    int off;
    int base_wr;
    int blen;
    int nslots;
    logic [7:0] d;
    logic [PAGE-1:0] touched;
    logic [7:0] stage [PAGE];
    bit expect_cyc;
    touched = '0;
    start_seen = 1'b1; @(negedge clk); start_seen = 1'b0;
    addr_in = a; addr_vld = 1'b1; @(negedge clk); addr_vld = 1'b0;
    off = int'(a) % PAGE;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      stage[off] = d;
      touched[off] = 1'b1;
      pulse_byte(d);
      off = (off + 1) % PAGE;
    end
    base_wr = wr_count;
    wp = wpv;
    if (abort) begin start_seen = 1'b1; @(negedge clk); start_seen = 1'b0; end
    else       begin stop_seen  = 1'b1; @(negedge clk); stop_seen  = 1'b0; end
    wp = 1'b0;
    expect_cyc = !abort && (n > 0) && !wpv;
    nslots = 0;
    if (expect_cyc) begin
      for (int s = 0; s < PAGE; s++)
        if (touched[s]) begin
          exp_arr[(int'(a) / PAGE) * PAGE + s] = stage[s];
          nslots++;
        end
      chk({req, " busy rises after stop (R2)"}, busy === 1'b1, int'(busy), 1);
      blen = 0;
      while (busy === 1'b1 && blen < CYC + 5) begin
        blen++;
        if (disturb) begin
          byte_in = 8'($urandom); byte_vld = 1'b1;
          stop_seen = 1'($urandom); start_seen = 1'($urandom);
          addr_in = 8'($urandom); addr_vld = 1'($urandom);
        end
        @(negedge clk);
        byte_vld = 1'b0; stop_seen = 1'b0; start_seen = 1'b0; addr_vld = 1'b0;
      end
      chk({req, " busy length (R2)"}, blen == CYC, blen, CYC);
      chk({req, " done pulse (R3)"}, done === 1'b1, int'(done), 1);
      @(negedge clk);
      chk({req, " done single (R3)"}, done === 1'b0, int'(done), 0);
      repeat (2) @(negedge clk);
      chk({req, " no relaunch (R9)"}, busy === 1'b0, int'(busy), 0);
    end else begin
      for (int k = 0; k < 3; k++) begin
        chk({req, " no cycle"}, busy === 1'b0, int'(busy), 0);
        @(negedge clk);
      end
    end
    chk({req, " write count (R7)"}, (wr_count - base_wr) == nslots, wr_count - base_wr, nslots);
    cmp_arrays({req, " array contents"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd91357));
    for (int i = 0; i < NWORDS; i++) begin arr[i] = 8'h00; exp_arr[i] = 8'h00; end
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", busy === 1'b0, int'(busy), 0);
    chk("R1 done at reset", done === 1'b0, int'(done), 0);
    chk("R1 mem_we at reset", mem_we === 1'b0, int'(mem_we), 0);
    rst = 1'b0;
    @(negedge clk);

    do_xfer(8'h10, 1, 1'b0, 1'b0, 1'b0, "R2 single byte");
    do_xfer(8'h23, 3, 1'b0, 1'b0, 1'b0, "R7 partial page");
    do_xfer(8'h46, 5, 1'b0, 1'b0, 1'b0, "R10 page wrap");
    do_xfer(8'h50, 11, 1'b0, 1'b0, 1'b0, "R8 overwrite");
    do_xfer(8'h30, 0, 1'b0, 1'b0, 1'b0, "R4 no data");
    do_xfer(8'h60, 4, 1'b1, 1'b0, 1'b0, "R6 protected");
    do_xfer(8'h70, 4, 1'b0, 1'b1, 1'b0, "R5 aborted");
    do_xfer(8'h80, 3, 1'b0, 1'b0, 1'b1, "R9 strobes while busy");
    do_xfer(8'hFF, 2, 1'b0, 1'b0, 1'b0, "R8 top slot wrap");

    for (int t = 0; t < 24; t++) begin
      do_xfer(8'($urandom), int'($urandom_range(0, 20)), ($urandom % 5) == 0,
              ($urandom % 8) == 0, ($urandom % 4) == 0, "R7 random");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule